// File: doc/BRIEF.md
# Chained Descriptor Channel Sequencer

This block runs one DMA channel through a chain of descriptors held in memory. On an enable pulse it reads a four-word descriptor through a simple word-read port. The four words are the source address, the destination address, a link word and a control word. The block copies them into working registers and starts an external data mover with a one-cycle start pulse. It then waits for the mover's done pulse. After that it either fetches the next descriptor named by the link word or returns to idle.

Software controls the channel through an enable pulse, a stop pulse, a chain-mode level and a clear pulse for the completed-descriptor counter. When chain mode is off, the channel runs one transfer from directly supplied registers and then finishes. A stop request is deferred until the descriptor in service has finished. Two one-cycle pulses are provided for an interrupt controller elsewhere: one for a completed descriptor that asked for notification, and one for the end of the whole chain.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, `busy` is 0, `done_count` is 0, and `rd_req`, `mv_start`, `desc_irq` and `chain_done` are all 0.
- R2: An enable pulse in idle with chain mode on raises `busy`. The block then reads the four words at `head_addr`, with its low 4 bits forced to zero, at offsets +0, +4, +8 and +12, in the order source, destination, link, control. Each read request and its address are held until `rd_ack`.
- R3: After the fourth word arrives, the mover gets a single-cycle `mv_start` with `mv_src` = source word, `mv_dst` = destination word and `mv_len` = control word bits [12:0]. The maximum length is 8191, and the upper control bits are ignored.
- R4: The next descriptor is fetched from the link word with its low 4 bits forced to zero. Link bit 0 is the stop-after-this flag and link bit 1 is the notify flag.
- R5: In the cycle a chained descriptor completes, `desc_irq` pulses for one cycle if its link bit 1 is set. It stays 0 otherwise.
- R6: `done_count` increments once per completed descriptor in chain mode. A `count_clear` pulse sets it to 0.
- R7: When a descriptor with link bit 0 set completes, `chain_done` pulses for one cycle, `busy` is 0 in the following cycle, and no further read is issued.
- R8: A `ch_stop` pulse while busy does not abort the descriptor in service. The chain ends when that descriptor's mover done arrives, and no further descriptor is fetched.
- R9: With chain mode off, an enable pulse runs one transfer from `direct_src`, `direct_dst` and `direct_len` with no memory reads. It pulses `chain_done`, leaves `done_count` unchanged and gives no `desc_irq`.
- R10: `ch_enable` while busy is ignored and does not disturb the running chain. `ch_stop` while idle is ignored and does not cut short the next chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_enable | input | 1 | Start pulse for the channel |
| ch_stop | input | 1 | Deferred stop request pulse |
| chain_mode | input | 1 | 1: walk descriptors, 0: single direct transfer |
| head_addr | input | 32 | First descriptor address (low 4 bits ignored) |
| direct_src | input | 32 | Source address for direct mode |
| direct_dst | input | 32 | Destination address for direct mode |
| direct_len | input | 13 | Byte length for direct mode |
| count_clear | input | 1 | Clears the completed-descriptor counter |
| busy | output | 1 | Channel enabled and not yet stopped |
| done_count | output | 16 | Completed descriptors in chain mode |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 32 | Word read address |
| rd_ack | input | 1 | Read data valid, completes the request |
| rd_data | input | 32 | Read data word |
| mv_start | output | 1 | One-cycle start for the data mover |
| mv_src | output | 32 | Transfer source address |
| mv_dst | output | 32 | Transfer destination address |
| mv_len | output | 13 | Transfer length in bytes |
| mv_done | input | 1 | Mover completion pulse |
| desc_irq | output | 1 | Notify pulse for a completed descriptor |
| chain_done | output | 1 | Pulse when the whole transfer ends |

## Verification
The hardest case to reach from the ports is a stop request that lands inside a service window. The request has to arrive after the mover has been started but before its done pulse, on a chain whose link words would otherwise keep going. The stimulus waits until the start pulse is seen, then issues the stop while the mover model is still holding back its done pulse. The scoreboard then expects exactly one mover command and four reads, with no fetch of the second descriptor. An enable pulse issued in the same window on a later chain shows that a second start is ignored.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   localparam int WORD_W     = 32;
   localparam int DESC_WORDS = 4;
   localparam int LINK_STOP  = 0;
   localparam int LINK_NOTE  = 1;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_XFER,
      ST_DECIDE
   } seq_state_e;

   typedef struct packed {
      logic [WORD_W-1:0] src;
      logic [WORD_W-1:0] dst;
      logic [WORD_W-1:0] link;
      logic [WORD_W-1:0] ctrl;
   } desc_t;
endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] go_addr,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [WORD_W-1:0] rd_data,
   output desc_t             words,
   output logic              done
);
   localparam int BASE_W = ADDR_W - 4;

   logic              active;
   logic [1:0]        idx;
   logic [BASE_W-1:0] base_q;
   logic [WORD_W-1:0] wq [DESC_WORDS];
   logic              take;

   assign take = active && rd_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         base_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= take && (idx == 2'd3);
         if (go) begin
            active <= 1'b1;
            idx    <= '0;
            base_q <= go_addr[ADDR_W-1:4];
         end else if (take) begin
            idx <= idx + 2'd1;
            if (idx == 2'd3) active <= 1'b0;
         end
      end
   end

   for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wq[w] <= '0;
         else if (take && (idx == 2'(w))) wq[w] <= rd_data;
      end
   end

   assign rd_req  = active;
   assign rd_addr = {base_q, idx, 2'b00};
   assign words   = '{src: wq[0], dst: wq[1], link: wq[2], ctrl: wq[3]};

   p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: rtl/dma_desc_counter.sv
module dma_desc_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] next_up;

   if (SATURATE) begin : g_sat
      assign next_up = (count == '1) ? count : count + 1'b1;
   end else begin : g_wrap
      assign next_up = count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= next_up;
   end

   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && count != '1) |=> (count == $past(count) + 1'b1));
   p_count_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_set,
   input  logic              stop_req,
   input  logic              chain_en,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [ADDR_W-1:0] dir_src,
   input  logic [ADDR_W-1:0] dir_dst,
   input  logic [LEN_W-1:0]  dir_len,
   output logic              fetch_go,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_done,
   input  desc_t             fetch_words,
   output logic              mv_start,
   output logic [ADDR_W-1:0] mv_src,
   output logic [ADDR_W-1:0] mv_dst,
   output logic [LEN_W-1:0]  mv_len,
   input  logic              mv_done,
   output logic              busy,
   output logic              cnt_inc,
   output logic              desc_irq,
   output logic              xfer_done
);
   seq_state_e        state;
   logic              stop_pend, chain_q, start_ok, in_decide, chain_end;
   logic [WORD_W-1:0] link_q;

   assign start_ok   = (state == ST_IDLE) && en_set;
   assign in_decide  = (state == ST_DECIDE);
   assign chain_end  = in_decide && (!chain_q || link_q[LINK_STOP] || stop_pend);
   assign fetch_go   = (start_ok && chain_en) || (in_decide && !chain_end);
   assign fetch_addr = start_ok ? head_addr : link_q[ADDR_W-1:0];
   assign cnt_inc    = in_decide && chain_q;
   assign desc_irq   = in_decide && chain_q && link_q[LINK_NOTE];
   assign xfer_done  = chain_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         busy      <= 1'b0;
         stop_pend <= 1'b0;
         chain_q   <= 1'b0;
         link_q    <= '0;
         mv_src    <= '0;
         mv_dst    <= '0;
         mv_len    <= '0;
         mv_start  <= 1'b0;
      end else begin
         mv_start <= 1'b0;
         if (stop_req && state != ST_IDLE) stop_pend <= 1'b1;
         case (state)
            ST_IDLE: if (en_set) begin
               busy      <= 1'b1;
               stop_pend <= 1'b0;
               chain_q   <= chain_en;
               if (chain_en) begin
                  state <= ST_FETCH;
               end else begin
                  mv_src   <= dir_src;
                  mv_dst   <= dir_dst;
                  mv_len   <= dir_len;
                  link_q   <= '0;
                  mv_start <= 1'b1;
                  state    <= ST_XFER;
               end
            end
            ST_FETCH: if (fetch_done) begin
               mv_src   <= fetch_words.src[ADDR_W-1:0];
               mv_dst   <= fetch_words.dst[ADDR_W-1:0];
               mv_len   <= fetch_words.ctrl[LEN_W-1:0];
               link_q   <= fetch_words.link;
               mv_start <= 1'b1;
               state    <= ST_XFER;
            end
            ST_XFER: if (mv_done && !mv_start) state <= ST_DECIDE;
            ST_DECIDE: begin
               if (chain_end) begin
                  state <= ST_IDLE;
                  busy  <= 1'b0;
               end else begin
                  state <= ST_FETCH;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mv_start |=> !mv_start);
   p_irq_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      desc_irq |-> busy);
   p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !busy);
   p_rise_on_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(en_set));
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 13,
   parameter int CNT_W     = 16,
   parameter bit CNT_SATUR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ch_enable,
   input  logic              ch_stop,
   input  logic              chain_mode,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [ADDR_W-1:0] direct_src,
   input  logic [ADDR_W-1:0] direct_dst,
   input  logic [LEN_W-1:0]  direct_len,
   input  logic              count_clear,
   output logic              busy,
   output logic [CNT_W-1:0]  done_count,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [WORD_W-1:0] rd_data,
   output logic              mv_start,
   output logic [ADDR_W-1:0] mv_src,
   output logic [ADDR_W-1:0] mv_dst,
   output logic [LEN_W-1:0]  mv_len,
   input  logic              mv_done,
   output logic              desc_irq,
   output logic              chain_done
);
   if (ADDR_W < 8 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("ADDR_W must lie between 8 and the word width");
   end
   if (LEN_W < 1 || LEN_W > WORD_W) begin : g_bad_len
      $error("LEN_W must fit inside the control word");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   logic              f_go, f_done, c_inc;
   logic [ADDR_W-1:0] f_addr;
   desc_t             f_words;

   dma_desc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(f_go), .go_addr(f_addr),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .words(f_words), .done(f_done)
   );

   dma_chain_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en_set(ch_enable), .stop_req(ch_stop),
      .chain_en(chain_mode), .head_addr(head_addr),
      .dir_src(direct_src), .dir_dst(direct_dst), .dir_len(direct_len),
      .fetch_go(f_go), .fetch_addr(f_addr), .fetch_done(f_done), .fetch_words(f_words),
      .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
      .mv_done(mv_done), .busy(busy), .cnt_inc(c_inc),
      .desc_irq(desc_irq), .xfer_done(chain_done)
   );

   dma_desc_counter #(.CNT_W(CNT_W), .SATURATE(CNT_SATUR)) u_count (
      .clk(clk), .rst_n(rst_n), .inc(c_inc), .clr(count_clear), .count(done_count)
   );

   p_reads_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);
endmodule

// File: tb/dma_chain_seq_test.sv
`timescale 1ns/1ps
module dma_chain_seq_test;
   logic        clk = 0, rst_n = 0;
   logic        ch_enable = 0, ch_stop = 0, chain_mode = 0, count_clear = 0;
   logic [31:0] head_addr = 0, direct_src = 0, direct_dst = 0, rd_data = 0;
   logic [12:0] direct_len = 0;
   logic        rd_ack = 0, mv_done = 0;
   logic        busy, rd_req, mv_start, desc_irq, chain_done;
   logic [15:0] done_count;
   logic [31:0] rd_addr, mv_src, mv_dst;
   logic [12:0] mv_len;

   int tests = 0, fails = 0;
   int irq_seen = 0, end_seen = 0, dly = 0;
   bit busy_chk = 0;
   logic [31:0] mem [256];
   logic [31:0] exp_rd [$];
   logic [76:0] exp_mv [$];

   always #2 clk = ~clk;

   dma_chain_seq uut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push_desc(logic [31:0] a);
      for (int k = 0; k < 4; k++) exp_rd.push_back({a[31:4], 4'h0} + 32'(4 * k));
      exp_mv.push_back({mem[a[9:2]], mem[a[9:2] + 8'd1], mem[a[9:2] + 8'd3][12:0]});
   endtask

   // read responder and address scoreboard (R2, R4)
   always @(negedge clk) begin
      if (rd_ack) rd_ack = 0;
      else if (rd_req) begin
         if (exp_rd.size() == 0) chk("R2 unexpected read", rd_addr, 32'hFFFF_FFFF);
         else chk("R2/R4 read address", rd_addr, exp_rd.pop_front());
         rd_data = mem[rd_addr[9:2]];
         rd_ack  = 1;
      end
   end

   // mover model and command scoreboard (R3)
   always @(negedge clk) begin
      mv_done = 0;
      if (dly > 0) begin
         dly--;
         if (dly == 0) mv_done = 1;
      end
      if (mv_start) begin
         if (exp_mv.size() == 0) chk("R3 unexpected start", 32'h1, 32'h0);
         else begin
            logic [76:0] e;
            e = exp_mv.pop_front();
            chk("R3 mover src", mv_src, e[76:45]);
            chk("R3 mover dst", mv_dst, e[44:13]);
            chk("R3 mover len", 32'(mv_len), 32'(e[12:0]));
         end
         dly = 4;
      end
   end

   // pulse monitor (R5, R7)
   always @(negedge clk) begin
      if (busy_chk) begin
         chk("R7 busy low after end", 32'(busy), 32'h0);
         busy_chk = 0;
      end
      if (desc_irq) irq_seen++;
      if (chain_done) begin
         end_seen++;
         busy_chk = 1;
      end
   end

   task automatic pulse_en();
      @(negedge clk) ch_enable = 1;
      @(negedge clk) ch_enable = 0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R2 read queue drained", 32'(exp_rd.size()), 32'h0);
      chk("R3 mover queue drained", 32'(exp_mv.size()), 32'h0);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
      // descriptor at 0x100: notify set, link 0x120
      mem[8'h40] = 32'h0000_1000; mem[8'h41] = 32'h0000_2000;
      mem[8'h42] = 32'h0000_0122; mem[8'h43] = 32'hABCD_0010;
      // descriptor at 0x120: no flags, link 0x14C with stray low bits
      mem[8'h48] = 32'h0000_1100; mem[8'h49] = 32'h0000_2100;
      mem[8'h4A] = 32'h0000_014C; mem[8'h4B] = 32'h0000_1FFF;
      // descriptor at 0x140: stop and notify
      mem[8'h50] = 32'h0000_1200; mem[8'h51] = 32'h0000_2200;
      mem[8'h52] = 32'h0000_0003; mem[8'h53] = 32'h0000_0004;

      repeat (3) @(negedge clk);
      chk("R1 busy at reset", 32'(busy), 0);
      chk("R1 count at reset", 32'(done_count), 0);
      chk("R1 quiet outputs", {rd_req, mv_start, desc_irq, chain_done}, 0);
      rst_n = 1;
      @(negedge clk);

      // R2 R3 R4 R5 R6 R7: full three-descriptor chain, head with stray bits
      chain_mode = 1; head_addr = 32'h105;
      push_desc(32'h100); push_desc(32'h120); push_desc(32'h140);
      irq_seen = 0; end_seen = 0;
      pulse_en();
      chk("R2 busy after enable", 32'(busy), 1);
      wait_idle();
      chk("R5 notify pulses", irq_seen, 2);
      chk("R7 end pulses", end_seen, 1);
      chk("R6 count after chain", 32'(done_count), 3);

      // R6 clear
      @(negedge clk) count_clear = 1;
      @(negedge clk) count_clear = 0;
      chk("R6 count cleared", 32'(done_count), 0);

      // R8 deferred stop during service
      head_addr = 32'h100;
      push_desc(32'h100);
      irq_seen = 0; end_seen = 0;
      pulse_en();
      while (!mv_start) @(negedge clk);
      ch_stop = 1;
      @(negedge clk) ch_stop = 0;
      chk("R8 still busy during service", 32'(busy), 1);
      wait_idle();
      chk("R8 one descriptor counted", 32'(done_count), 1);
      chk("R8 notify of served descriptor", irq_seen, 1);
      chk("R8 end pulse", end_seen, 1);

      // R9 direct mode
      chain_mode = 0;
      direct_src = 32'h3000; direct_dst = 32'h4000; direct_len = 13'd100;
      exp_mv.push_back({32'h3000, 32'h4000, 13'd100});
      irq_seen = 0; end_seen = 0;
      pulse_en();
      wait_idle();
      chk("R9 count unchanged", 32'(done_count), 1);
      chk("R9 no notify", irq_seen, 0);
      chk("R9 end pulse", end_seen, 1);

      // R10 stop while idle, enable while busy
      chain_mode = 1; head_addr = 32'h100;
      @(negedge clk) ch_stop = 1;
      @(negedge clk) ch_stop = 0;
      push_desc(32'h100); push_desc(32'h120); push_desc(32'h140);
      irq_seen = 0; end_seen = 0;
      pulse_en();
      while (!mv_start) @(negedge clk);
      ch_enable = 1;
      @(negedge clk) ch_enable = 0;
      wait_idle();
      chk("R10 full chain count", 32'(done_count), 4);
      chk("R10 single end pulse", end_seen, 1);
      chk("R10 notify pulses", irq_seen, 2);

      summary();
   end
endmodule